// File: doc/BRIEF.md
# Matrix-Vector Multiply-Accumulate Engine

This engine forms three 32-bit accumulator results from a 3x3 matrix of signed 16-bit coefficients, a signed 16-bit three-element vector and a signed 32-bit offset vector. Each result is `(offset << 12) + row · vector`, summed in 64 bits. The sum may be scaled down by 12 bits before the low 32 bits are stored. A run also yields an overflow word that records, for each channel, whether the 64-bit value left the signed 32-bit range, and in which direction.

One 32-bit command word, latched at start, picks the matrix, the vector, the offset set and the scaling. All operand sets come in as flat buses that reflect a small register file: three matrices, three vectors, a separate intermediate vector, and three offset sets. A single shared 16x16 multiplier processes the channels one after another. Each channel takes three cycles. A one-cycle `done` pulse follows the last channel.

The controller has three states:
- `ST_IDLE` waits for `start`. The transition "launch" moves to `ST_RUN`.
- `ST_RUN` steps through the channel and term counters. The transition "finish" moves to `ST_DONE` after the third term of the third channel.
- `ST_DONE` raises `done` for one cycle. The transition "retire" returns to `ST_IDLE`.

Top module: `mvma_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0, all three results are 0 and `ovf_flags` is 0.
- R2: A `start` seen in `ST_IDLE` makes `busy` high for exactly 9 cycles. `done` is then high for exactly one cycle, and `busy` and `done` are never high together.
- R3: With command bit 19 clear, result i equals the low 32 bits of `(sext64(CVi) << 12) + Σj Mij·Vj`.
- R4: With command bit 19 set, the 64-bit sum is arithmetically shifted right by 12 before storage and before the overflow test.
- R5: Command bits 18:17 select matrix 0..2, bits 16:15 select vector 0..2, and bits 14:13 select offset set 0..2. Matrix k entry (r,c) is at `mat_bus[(k*9+r*3+c)*16 +: 16]`. Vector k element j is at `vec_bus[(k*3+j)*16 +: 16]`. Offset set k channel i is at `cv_bus[(k*3+i)*32 +: 32]`.
- R6: A vector select of 3 uses `ir_bus` (element j at `ir_bus[j*16 +: 16]`). A matrix select of 3 uses an all-zero matrix. An offset select of 3 uses zero offsets.
- R7: If the (possibly shifted) 64-bit value of channel 1, 2 or 3 exceeds 2^31-1, bit 30, 29 or 28 of `ovf_flags` is set, respectively.
- R8: If that value is below -2^31, bit 27, 26 or 25 is set for channel 1, 2 or 3, together with bit 31. Bit 31 is never set without one of bits 27..25.
- R9: When `flag_dis` is high at start, `ovf_flags` reads 0 at the end of the run, whatever the results.
- R10: A `start` raised while a run is active or during the `done` cycle is ignored. The results follow the command latched at the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| cmd | input | 32 | Command word: scaling bit 19, matrix 18:17, vector 16:15, offset 14:13 |
| flag_dis | input | 1 | Suppress overflow flags for this run |
| mat_bus | input | 432 | Three 3x3 matrices of signed 16-bit entries |
| vec_bus | input | 144 | Three vectors of three signed 16-bit elements |
| ir_bus | input | 48 | Intermediate vector, three signed 16-bit elements |
| cv_bus | input | 288 | Three offset sets of three signed 32-bit values |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| mac_ch1 | output | 32 | Channel 1 result |
| mac_ch2 | output | 32 | Channel 2 result |
| mac_ch3 | output | 32 | Channel 3 result |
| ovf_flags | output | 32 | Overflow flag word |

## Verification
The cycle that writes the third channel's result and flags also triggers "finish". The `done` cycle that follows is the only place where a new `start` could meet a retiring run. The bench pulses `start` with a different command exactly in the `done` cycle and also in the middle of a run. It judges both cases by checking that `busy` stays low afterwards and that the results still match the first command. Positive and negative overflow of different channels also land in the same flag word in one run. Extreme operand patterns swept over all 128 command variants provoke that mix, and every flag bit is compared against a 64-bit model.

// File: rtl/mvma_pkg.sv
package mvma_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} state_t;

    localparam int SCALE_BIT = 19;
    localparam int MSEL_LSB  = 17;
    localparam int VSEL_LSB  = 15;
    localparam int CSEL_LSB  = 13;
    localparam int POS_TOP   = 30;
    localparam int NEG_TOP   = 27;
    localparam int NEG_SUM   = 31;
endpackage

// File: rtl/mvma_opsel.sv
module mvma_opsel #(
    parameter int DW = 16,
    parameter int CW = 32,
    parameter int N  = 3
) (
    input  logic [N*N*N*DW-1:0] mat_bus,
    input  logic [N*N*DW-1:0]   vec_bus,
    input  logic [N*DW-1:0]     ir_bus,
    input  logic [N*N*CW-1:0]   cv_bus,
    input  logic [1:0]          msel,
    input  logic [1:0]          vsel,
    input  logic [1:0]          csel,
    input  logic [1:0]          ch,
    input  logic [1:0]          term,
    output logic [DW-1:0]       m_op,
    output logic [DW-1:0]       v_op,
    output logic [CW-1:0]       cv_op
);
    logic [DW-1:0] mat_a [N][N][N];
    logic [DW-1:0] vec_a [N][N];
    logic [DW-1:0] ir_a  [N];
    logic [CW-1:0] cv_a  [N][N];

    for (genvar k = 0; k < N; k++) begin : g_set
        for (genvar a = 0; a < N; a++) begin : g_row
            assign vec_a[k][a] = vec_bus[(k*N+a)*DW +: DW];
            assign cv_a[k][a]  = cv_bus[(k*N+a)*CW +: CW];
            for (genvar b = 0; b < N; b++) begin : g_col
                assign mat_a[k][a][b] = mat_bus[((k*N+a)*N+b)*DW +: DW];
            end
        end
    end
    for (genvar j = 0; j < N; j++) begin : g_ir
        assign ir_a[j] = ir_bus[j*DW +: DW];
    end

    always_comb begin
        m_op  = '0;
        v_op  = '0;
        cv_op = '0;
        if (int'(ch) < N && int'(term) < N) begin
            if (int'(msel) < N) m_op = mat_a[msel][ch][term];
            v_op = (int'(vsel) < N) ? vec_a[vsel][term] : ir_a[term];
            if (int'(csel) < N) cv_op = cv_a[csel][ch];
        end
    end
endmodule

// File: rtl/mvma_acc.sv
module mvma_acc #(
    parameter int DW   = 16,
    parameter int CW   = 32,
    parameter int AW   = 64,
    parameter int FRAC = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          first,
    input  logic          scale,
    input  logic [DW-1:0] m_op,
    input  logic [DW-1:0] v_op,
    input  logic [CW-1:0] cv_op,
    output logic [CW-1:0] res,
    output logic          pos_ovf,
    output logic          neg_ovf
);
    localparam int PW = 2 * DW;
    localparam logic signed [AW-1:0] RMAX = (AW'(1) <<< (CW - 1)) - AW'(1);
    localparam logic signed [AW-1:0] RMIN = -(AW'(1) <<< (CW - 1));

    logic signed [AW-1:0] acc_q, base, acc_next, scaled;
    logic signed [PW-1:0] prod;

    assign prod     = $signed(m_op) * $signed(v_op);
    assign base     = first ? (AW'($signed(cv_op)) <<< FRAC) : acc_q;
    assign acc_next = base + AW'(prod);
    assign scaled   = scale ? (acc_next >>> FRAC) : acc_next;
    assign res      = scaled[CW-1:0];
    assign pos_ovf  = scaled > RMAX;
    assign neg_ovf  = scaled < RMIN;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  acc_q <= '0;
        else if (en) acc_q <= acc_next;
    end

    p_ovf_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pos_ovf && neg_ovf));
endmodule

// File: rtl/mvma_engine.sv
module mvma_engine #(
    parameter int DW   = 16,
    parameter int CW   = 32,
    parameter int AW   = 64,
    parameter int FRAC = 12,
    parameter int N    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [31:0]         cmd,
    input  logic                flag_dis,
    input  logic [N*N*N*DW-1:0] mat_bus,
    input  logic [N*N*DW-1:0]   vec_bus,
    input  logic [N*DW-1:0]     ir_bus,
    input  logic [N*N*CW-1:0]   cv_bus,
    output logic                busy,
    output logic                done,
    output logic [CW-1:0]       mac_ch1,
    output logic [CW-1:0]       mac_ch2,
    output logic [CW-1:0]       mac_ch3,
    output logic [31:0]         ovf_flags
);
    import mvma_pkg::*;

    localparam logic [1:0] LAST = 2'(N - 1);

    state_t        state_q, state_d;
    logic [1:0]    ch_q, term_q;
    logic          scale_q, fdis_q;
    logic [1:0]    msel_q, vsel_q, csel_q;
    logic [CW-1:0] mac_q [N];
    logic [31:0]   flags_q;
    logic [DW-1:0] m_op, v_op;
    logic [CW-1:0] cv_op, res;
    logic          pos_ovf, neg_ovf, last_term, launch;

    assign last_term = (term_q == LAST);
    assign launch    = (state_q == ST_IDLE) && start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_RUN;
            ST_RUN:  if (last_term && ch_q == LAST) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN:  busy = 1'b1;
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q    <= '0;
            term_q  <= '0;
            scale_q <= 1'b0;
            fdis_q  <= 1'b0;
            msel_q  <= '0;
            vsel_q  <= '0;
            csel_q  <= '0;
            flags_q <= '0;
            for (int i = 0; i < N; i++) mac_q[i] <= '0;
        end else if (launch) begin
            ch_q    <= '0;
            term_q  <= '0;
            scale_q <= cmd[SCALE_BIT];
            msel_q  <= cmd[MSEL_LSB +: 2];
            vsel_q  <= cmd[VSEL_LSB +: 2];
            csel_q  <= cmd[CSEL_LSB +: 2];
            fdis_q  <= flag_dis;
            flags_q <= '0;
        end else if (state_q == ST_RUN) begin
            if (last_term) begin
                term_q        <= '0;
                ch_q          <= ch_q + 2'd1;
                mac_q[ch_q]   <= res;
                if (!fdis_q && pos_ovf) flags_q[POS_TOP - int'(ch_q)] <= 1'b1;
                if (!fdis_q && neg_ovf) begin
                    flags_q[NEG_TOP - int'(ch_q)] <= 1'b1;
                    flags_q[NEG_SUM]              <= 1'b1;
                end
            end else begin
                term_q <= term_q + 2'd1;
            end
        end
    end

    mvma_opsel #(.DW(DW), .CW(CW), .N(N)) u_sel (
        .mat_bus(mat_bus), .vec_bus(vec_bus), .ir_bus(ir_bus), .cv_bus(cv_bus),
        .msel(msel_q), .vsel(vsel_q), .csel(csel_q), .ch(ch_q), .term(term_q),
        .m_op(m_op), .v_op(v_op), .cv_op(cv_op)
    );

    mvma_acc #(.DW(DW), .CW(CW), .AW(AW), .FRAC(FRAC)) u_acc (
        .clk(clk), .rst_n(rst_n), .en(state_q == ST_RUN), .first(term_q == 2'd0),
        .scale(scale_q), .m_op(m_op), .v_op(v_op), .cv_op(cv_op),
        .res(res), .pos_ovf(pos_ovf), .neg_ovf(neg_ovf)
    );

    assign mac_ch1   = mac_q[0];
    assign mac_ch2   = mac_q[1];
    assign mac_ch3   = mac_q[2];
    assign ovf_flags = flags_q;

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_busy_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    p_neg_sum_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((|ovf_flags[27:25]) == ovf_flags[31]));
    p_dir_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(ovf_flags[30] && ovf_flags[27]) && !(ovf_flags[29] && ovf_flags[26])
                 && !(ovf_flags[28] && ovf_flags[25]));
    p_flag_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fdis_q) |-> (ovf_flags == 32'd0));
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(msel_q) && $stable(vsel_q) && $stable(csel_q));
endmodule

// File: tb/sim_mvma_engine.sv
module sim_mvma_engine;
    localparam longint LMAX = 64'sd2147483647;
    localparam longint LMIN = -LMAX - 64'sd1;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, flag_dis = 1'b0;
    logic [31:0] cmd = '0;
    logic [431:0] mat_bus;
    logic [143:0] vec_bus;
    logic [47:0]  ir_bus;
    logic [287:0] cv_bus;
    logic busy, done;
    logic [31:0] mac_ch1, mac_ch2, mac_ch3, ovf_flags;

    shortint bm [3][3][3];
    shortint bv [3][3];
    shortint bir [3];
    int      bcv [3][3];
    int checks = 0, fails = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int k = 0; k < 3; k++)
            for (int a = 0; a < 3; a++) begin
                vec_bus[(k*3+a)*16 +: 16] = bv[k][a];
                cv_bus[(k*3+a)*32 +: 32]  = bcv[k][a];
                for (int b = 0; b < 3; b++)
                    mat_bus[((k*3+a)*3+b)*16 +: 16] = bm[k][a][b];
            end
        for (int j = 0; j < 3; j++) ir_bus[j*16 +: 16] = bir[j];
    end

    mvma_engine u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model(input logic [31:0] c, input bit fd,
                                  output logic [31:0] e [3], output logic [31:0] ef);
        int mx = int'(c[18:17]), vs = int'(c[16:15]), cs = int'(c[14:13]);
        ef = '0;
        for (int i = 0; i < 3; i++) begin
            longint s = (cs == 3) ? 64'sd0 : (longint'(bcv[cs][i]) <<< 12);
            for (int j = 0; j < 3; j++) begin
                longint mm = (mx == 3) ? 64'sd0 : longint'(bm[mx][i][j]);
                longint vv = (vs == 3) ? longint'(bir[j]) : longint'(bv[vs][j]);
                s += mm * vv;
            end
            if (c[19]) s = s >>> 12;
            e[i] = s[31:0];
            if (!fd && s > LMAX) ef[30-i] = 1'b1;
            if (!fd && s < LMIN) begin ef[27-i] = 1'b1; ef[31] = 1'b1; end
        end
    endfunction

    task automatic run(input logic [31:0] c, input bit fd, input int poke, output int nbusy);
        @(negedge clk); start = 1'b1; cmd = c; flag_dis = fd;
        @(negedge clk); start = 1'b0; cmd = ~c; flag_dis = ~fd;
        nbusy = 0;
        for (int t = 0; t < 40 && !done; t++) begin
            if (busy) nbusy++;
            start = (t == poke);
            @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic judge(input logic [31:0] c, input bit fd, input string tag);
        logic [31:0] e [3];
        logic [31:0] ef;
        model(c, fd, e, ef);
        chk({tag, " ch1 R5"}, mac_ch1, e[0]);
        chk({tag, " ch2 R5"}, mac_ch2, e[1]);
        chk({tag, " ch3 R5"}, mac_ch3, e[2]);
        chk(fd ? "flags R9" : "flags R7 R8", ovf_flags, ef);
    endtask

    function automatic shortint pick16(input int p);
        logic [1:0] r = 2'($urandom);
        if (p == 1) return (r == 0) ? 16'sh7FFF : (r == 1) ? -16'sh8000 : (r == 2) ? 16'sd0 : 16'sd1;
        return shortint'($urandom);
    endfunction

    function automatic int pick32(input int p);
        logic [1:0] r = 2'($urandom);
        if (p == 1) return (r == 0) ? 32'sh7FFFFFFF : (r == 1) ? 32'sh80000000 : (r == 2) ? 0 : 1;
        if (p == 2) return int'($urandom % 2000) - 1000;
        return int'($urandom);
    endfunction

    task automatic fill(input int p);
        for (int k = 0; k < 3; k++)
            for (int a = 0; a < 3; a++) begin
                bv[k][a] = pick16(p);
                bcv[k][a] = pick32(p);
                for (int b = 0; b < 3; b++) bm[k][a][b] = pick16(p);
            end
        for (int j = 0; j < 3; j++) bir[j] = pick16(p);
    endtask

    initial begin
        int nb;
        fill(0);
        repeat (3) @(negedge clk);
        chk("reset R1 busy", {31'd0, busy}, 32'd0);
        chk("reset R1 done", {31'd0, done}, 32'd0);
        chk("reset R1 mac", mac_ch1 | mac_ch2 | mac_ch3, 32'd0);
        chk("reset R1 flags", ovf_flags, 32'd0);
        rst_n = 1'b1;

        for (int p = 0; p < 3; p++) begin
            fill(p);
            for (int n = 0; n < 128; n++) begin
                logic [31:0] c = {12'h0, n[6], n[5:4], n[3:2], n[1:0], 13'h0};
                bit fd = (n % 7 == 3);
                string tag = (c[18:17] == 3 || c[16:15] == 3 || c[14:13] == 3) ? "R6" :
                             (c[19] ? "R4" : "R3");
                run(c, fd, -1, nb);
                chk("R2 busy cycles", nb, 32'd9);
                judge(c, fd, tag);
                @(negedge clk);
                chk("R2 single done", {31'd0, done}, 32'd0);
            end
        end

        fill(1);
        run(32'h0000_2000, 1'b0, 4, nb);
        judge(32'h0000_2000, 1'b0, "R10 mid-run start");
        start = 1'b1; cmd = 32'h0008_4000;
        @(negedge clk); start = 1'b0;
        chk("R10 start in done cycle", {31'd0, busy}, 32'd0);
        judge(32'h0000_2000, 1'b0, "R10 kept");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R2 actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule